// File: doc/BRIEF.md
# Banked SRAM Access Sequencer

This block drives the control lines of a memory built from several identical sub-arrays (banks). A host presents one word address together with a read or write flag. The sequencer splits the address into bank, row and column fields. It then steps the addressed bank through a fixed series of phases: bit-line precharge, word-line activation, sense-amplifier isolation, and for reads, data capture. Banks that are not addressed receive no enable at any point, so they draw no switching power.

The length of the word-line pulse is not a fixed cycle count. A replica column inside the array pulls an active-low completion line when its bit line has swung far enough, and the pulse ends on that event. A programmable cycle limit acts as a safety net if the completion line never falls. When the limit ends the pulse, a sticky error flag is raised. The host side is a simple valid/ready handshake. Read results come back with a one-cycle valid strobe, and the ready line returns high in that same cycle.

Top module: `sram_bank_seq`

## Requirements
- R1: The address is split as {bank, row, column}, with the column in the COL_W least significant bits, the row in the next ROW_W bits and the bank in the top BANK_W bits. Bit i of `bank_en`, `wordline` or `col_sel` is asserted only when the matching field equals i.
- R2: `bank_en` is one-hot during precharge, word-line and isolation phases and all-zero when idle. Whenever a word line is up, the addressed bank is enabled.
- R3: At most one bit of `wordline` is high in any cycle. All word lines are low while `precharge` is high and while idle.
- R4: An accepted request produces exactly PRE_CYCLES cycles of `precharge`, starting the cycle after acceptance. No word line rises before precharge is complete.
- R5: The selected word line rises in the cycle after the last precharge cycle. It stays high until `done_n` is sampled low at a rising edge, and falls at that edge. The pulse therefore lasts as many cycles as `done_n` took to fall.
- R6: When the word line falls, `sense_iso` is high for exactly one cycle and all word lines are low in that cycle.
- R7: For a write, `write_en` is high in every word-line cycle and `wr_data` carries the request's data. `sense_en` stays low, and a later read of the same address returns the written word.
- R8: For a read, `rd_valid` is high for exactly one cycle, the cycle after the isolation cycle. `req_ready` is high in that cycle. `rd_data` equals the word that `sense_data` held at the end of the isolation cycle.
- R9: If `done_n` is still high after max(`tmo_limit`,1) word-line cycles, the word line is dropped and `err_timeout` is set. No `rd_valid` follows, and the flag stays set until the next request is accepted. If `done_n` falls in the same cycle the limit is reached, completion wins and no error is raised.
- R10: `req_ready` is high only when idle, including straight after reset. A request presented while `req_ready` is low has no effect: it starts no cycle and changes no stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request strobe |
| req_ready | output | 1 | Sequencer idle, request will be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | BANK_W+ROW_W+COL_W | Word address {bank,row,column} |
| req_wdata | input | DATA_W | Write data |
| tmo_limit | input | TMO_W | Word-line cycle limit (0 behaves as 1) |
| bank_en | output | 2**BANK_W | One-hot bank activation |
| wordline | output | 2**ROW_W | One-hot word lines, shared by banks and gated by bank_en |
| col_sel | output | 2**COL_W | One-hot column select |
| precharge | output | 1 | Bit-line precharge enable |
| sense_en | output | 1 | Sense amplifier enable (reads) |
| sense_iso | output | 1 | Sense amplifier isolation from bit lines |
| write_en | output | 1 | Write driver enable |
| wr_data | output | DATA_W | Data for the write drivers |
| done_n | input | 1 | Replica-column completion, active low |
| sense_data | input | DATA_W | Sense amplifier outputs |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | DATA_W | Captured read word |
| err_timeout | output | 1 | Word-line pulse ended by the cycle limit |

## Verification
The bound checker watches, on every cycle, the rules that can be seen at the ports. These are: one-hot word lines and bank enables, no word line during precharge, a word line only inside an enabled bank, the word line falling right after completion is sampled, isolation in the cycle the pulse ends, and the pulse staying within the cycle limit. It also checks the single-cycle read strobe that coincides with ready, and ready dropping after every acceptance. Other properties depend on what the array holds, so only the bench scenarios can show them. These include correct field decoding of each address, write data landing at the right cell without aliasing, the read word matching a reference copy, exact precharge and pulse lengths for several completion delays, the tie between completion and the limit, and a request held off while busy leaving the contents untouched.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

   // Phase of one access; encoding is internal to the sequencer.
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_PRE  = 2'd1,
      PH_WL   = 2'd2,
      PH_ISO  = 2'd3
   } phase_e;

endpackage

// File: rtl/sram_seq_onehot_dec.sv
// Enabled binary-to-one-hot decoder used for banks, rows and columns.
module sram_seq_onehot_dec #(
   parameter int SEL_W = 2,
   parameter int N_OUT = 1 << SEL_W
) (
   input  logic [SEL_W-1:0] sel,
   input  logic             en,
   output logic [N_OUT-1:0] hot
);

   generate
      for (genvar i = 0; i < N_OUT; i++) begin : g_line
         assign hot[i] = en && (sel == SEL_W'(i));
      end
   endgenerate

endmodule

// File: rtl/sram_seq_ctrl.sv
// Phase sequencer: precharge length, self-timed word line, limit timer.
module sram_seq_ctrl #(
   parameter int PRE_CYCLES = 2,
   parameter int TMO_W      = 6
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic                  done_n,
   input  logic [TMO_W-1:0]      limit,
   output sram_seq_pkg::phase_e  phase,
   output logic                  tmo_evt
);
   import sram_seq_pkg::*;

   localparam int PRE_W = $clog2(PRE_CYCLES + 1);
   localparam int CNT_W = ((TMO_W > PRE_W) ? TMO_W : PRE_W) + 1;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cnt_inc;
   logic [CNT_W-1:0] lim_ext;
   logic             pre_last;
   logic             wl_expired;
   phase_e           nxt;

   assign cnt_inc = cnt + 1'b1;
   assign lim_ext = {{(CNT_W-TMO_W){1'b0}}, limit};

   generate
      if (PRE_CYCLES == 1) begin : g_pre_single
         assign pre_last = 1'b1;
      end else begin : g_pre_multi
         assign pre_last = (cnt == CNT_W'(PRE_CYCLES - 1));
      end
   endgenerate

   // Limit of zero behaves as one: cnt_inc is at least one.
   assign wl_expired = (cnt_inc >= lim_ext);
   assign tmo_evt    = (phase == PH_WL) && done_n && wl_expired;

   always_comb begin
      nxt = phase;
      unique case (phase)
         PH_IDLE: if (start)                    nxt = PH_PRE;
         PH_PRE:  if (pre_last)                 nxt = PH_WL;
         PH_WL:   if (!done_n || wl_expired)    nxt = PH_ISO;
         PH_ISO:                                nxt = PH_IDLE;
         default:                               nxt = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
      end else begin
         phase <= nxt;
         if (nxt != phase || phase == PH_IDLE) cnt <= '0;
         else                                  cnt <= cnt_inc;
      end
   end

endmodule

// File: rtl/sram_bank_seq.sv
// Banked SRAM access sequencer, top level.
module sram_bank_seq
   import sram_seq_pkg::*;
#(
   parameter int BANK_W     = 2,
   parameter int ROW_W      = 5,
   parameter int COL_W      = 2,
   parameter int DATA_W     = 8,
   parameter int TMO_W      = 6,
   parameter int PRE_CYCLES = 2
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             req_valid,
   output logic                             req_ready,
   input  logic                             req_write,
   input  logic [BANK_W+ROW_W+COL_W-1:0]    req_addr,
   input  logic [DATA_W-1:0]                req_wdata,
   input  logic [TMO_W-1:0]                 tmo_limit,
   output logic [(1<<BANK_W)-1:0]           bank_en,
   output logic [(1<<ROW_W)-1:0]            wordline,
   output logic [(1<<COL_W)-1:0]            col_sel,
   output logic                             precharge,
   output logic                             sense_en,
   output logic                             sense_iso,
   output logic                             write_en,
   output logic [DATA_W-1:0]                wr_data,
   input  logic                             done_n,
   input  logic [DATA_W-1:0]                sense_data,
   output logic                             rd_valid,
   output logic [DATA_W-1:0]                rd_data,
   output logic                             err_timeout
);

   localparam int ADDR_W = BANK_W + ROW_W + COL_W;
   localparam int NBANK  = 1 << BANK_W;
   localparam int NROW   = 1 << ROW_W;
   localparam int NCOL   = 1 << COL_W;

   // Elaboration-time parameter checks.
   generate
      if (BANK_W < 1 || ROW_W < 1 || COL_W < 1) begin : g_bad_fields
         $error("sram_bank_seq: every address field needs at least one bit");
      end
      if (ADDR_W > 24) begin : g_bad_addr
         $error("sram_bank_seq: address wider than the decoders are meant for");
      end
      if (PRE_CYCLES < 1) begin : g_bad_pre
         $error("sram_bank_seq: precharge needs at least one cycle");
      end
      if (TMO_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("sram_bank_seq: limit and data widths must be positive");
      end
   endgenerate

   phase_e              phase;
   logic                tmo_evt;
   logic                accept;
   logic [BANK_W-1:0]   cur_bank;
   logic [ROW_W-1:0]    cur_row;
   logic [COL_W-1:0]    cur_col;
   logic                cur_wr;
   logic [DATA_W-1:0]   cur_wdata;
   logic                bank_on;
   logic                row_on;
   logic                col_on;

   assign req_ready = (phase == PH_IDLE);
   assign accept    = req_valid && req_ready;

   // Request capture: fields held stable for the whole access.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_bank  <= '0;
         cur_row   <= '0;
         cur_col   <= '0;
         cur_wr    <= 1'b0;
         cur_wdata <= '0;
      end else if (accept) begin
         {cur_bank, cur_row, cur_col} <= req_addr;
         cur_wr    <= req_write;
         cur_wdata <= req_wdata;
      end
   end

   sram_seq_ctrl #(
      .PRE_CYCLES (PRE_CYCLES),
      .TMO_W      (TMO_W)
   ) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (accept),
      .done_n  (done_n),
      .limit   (tmo_limit),
      .phase   (phase),
      .tmo_evt (tmo_evt)
   );

   assign bank_on = (phase != PH_IDLE);
   assign row_on  = (phase == PH_WL);
   assign col_on  = (phase == PH_WL) || (phase == PH_ISO);

   sram_seq_onehot_dec #(.SEL_W(BANK_W), .N_OUT(NBANK)) u_bank_dec (
      .sel (cur_bank), .en (bank_on), .hot (bank_en)
   );
   sram_seq_onehot_dec #(.SEL_W(ROW_W), .N_OUT(NROW)) u_row_dec (
      .sel (cur_row), .en (row_on), .hot (wordline)
   );
   sram_seq_onehot_dec #(.SEL_W(COL_W), .N_OUT(NCOL)) u_col_dec (
      .sel (cur_col), .en (col_on), .hot (col_sel)
   );

   assign precharge = (phase == PH_PRE);
   assign sense_en  = (phase == PH_WL) && !cur_wr;
   assign write_en  = (phase == PH_WL) &&  cur_wr;
   assign sense_iso = (phase == PH_ISO);
   assign wr_data   = cur_wdata;

   // Error flag, read capture and strobe.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_timeout <= 1'b0;
         rd_valid    <= 1'b0;
         rd_data     <= '0;
      end else begin
         if (accept)       err_timeout <= 1'b0;
         else if (tmo_evt) err_timeout <= 1'b1;

         rd_valid <= (phase == PH_ISO) && !cur_wr && !err_timeout;
         if ((phase == PH_ISO) && !cur_wr && !err_timeout)
            rd_data <= sense_data;
      end
   end

endmodule

// File: rtl/sram_bank_seq_chk.sv
// Port-level protocol checker, bound into the sequencer.
module sram_bank_seq_chk #(
   parameter int BANK_W = 2,
   parameter int ROW_W  = 5,
   parameter int TMO_W  = 6
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   req_valid,
   input logic                   req_ready,
   input logic [TMO_W-1:0]       tmo_limit,
   input logic [(1<<BANK_W)-1:0] bank_en,
   input logic [(1<<ROW_W)-1:0]  wordline,
   input logic                   precharge,
   input logic                   sense_en,
   input logic                   sense_iso,
   input logic                   write_en,
   input logic                   done_n,
   input logic                   rd_valid
);

   logic [TMO_W:0] wl_run;
   logic [TMO_W:0] lim_eff;

   assign lim_eff = (tmo_limit == '0) ? (TMO_W+1)'(1) : {1'b0, tmo_limit};

   // Consecutive word-line cycles seen before the current one.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         wl_run <= '0;
      else if (|wordline) wl_run <= (&wl_run) ? wl_run : wl_run + 1'b1;
      else                wl_run <= '0;
   end

   p_onehot_wl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wordline));

   p_pre_no_wl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      precharge |-> (wordline == '0));

   p_onehot_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_en));

   p_wl_in_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (|wordline) |-> $onehot(bank_en));

   p_done_drops_wl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((|wordline) && !done_n) |=> (wordline == '0));

   p_iso_at_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(|wordline) |-> sense_iso);

   p_write_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      write_en |-> (!sense_en && (|wordline)));

   p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);

   p_valid_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> req_ready);

   p_pulse_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (|wordline) |-> (wl_run < lim_eff));

   p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

endmodule

bind sram_bank_seq sram_bank_seq_chk #(
   .BANK_W (BANK_W),
   .ROW_W  (ROW_W),
   .TMO_W  (TMO_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .tmo_limit (tmo_limit),
   .bank_en   (bank_en),
   .wordline  (wordline),
   .precharge (precharge),
   .sense_en  (sense_en),
   .sense_iso (sense_iso),
   .write_en  (write_en),
   .done_n    (done_n),
   .rd_valid  (rd_valid)
);

// File: tb/sim_sram_bank_seq.sv
module sim_sram_bank_seq;

   localparam int BANK_W = 2;
   localparam int ROW_W  = 5;
   localparam int COL_W  = 2;
   localparam int DATA_W = 8;
   localparam int TMO_W  = 6;
   localparam int PRE_C  = 2;
   localparam int ADDR_W = BANK_W + ROW_W + COL_W;
   localparam int NWORD  = 1 << ADDR_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [DATA_W-1:0] req_wdata = '0;
   logic [TMO_W-1:0]  tmo_limit = TMO_W'(12);
   logic done_n = 1'b1;
   logic [DATA_W-1:0] sense_data = '0;
   logic req_ready, precharge, sense_en, sense_iso, write_en, rd_valid, err_timeout;
   logic [(1<<BANK_W)-1:0] bank_en;
   logic [(1<<ROW_W)-1:0]  wordline;
   logic [(1<<COL_W)-1:0]  col_sel;
   logic [DATA_W-1:0] wr_data, rd_data;

   sram_bank_seq #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
                   .TMO_W(TMO_W), .PRE_CYCLES(PRE_C)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .tmo_limit(tmo_limit), .bank_en(bank_en), .wordline(wordline), .col_sel(col_sel),
      .precharge(precharge), .sense_en(sense_en), .sense_iso(sense_iso),
      .write_en(write_en), .wr_data(wr_data), .done_n(done_n), .sense_data(sense_data),
      .rd_valid(rd_valid), .rd_data(rd_data), .err_timeout(err_timeout));

   always #5 clk = ~clk;

   int n_tests = 0, n_fail = 0;

   // Behavioural array and independent reference copy.
   logic [DATA_W-1:0] arr  [NWORD];
   logic [DATA_W-1:0] refm [NWORD];
   int dly_cfg = 1;
   int run = 0;

   // Per-access observations.
   int st_pre, st_wl, st_iso, st_rdv;
   bit st_order_bad, st_oh_bad, st_bank_bad, st_iso_bad, st_rdv_bad, prev_iso;
   int obs_bank, obs_row, obs_col;
   logic [DATA_W-1:0] st_rdata;

   task automatic clear_stats();
      st_pre = 0; st_wl = 0; st_iso = 0; st_rdv = 0;
      st_order_bad = 0; st_oh_bad = 0; st_bank_bad = 0; st_iso_bad = 0; st_rdv_bad = 0;
      obs_bank = -1; obs_row = -1; obs_col = -1; st_rdata = '0;
   endtask

   // Array, replica column and monitor, evaluated at falling edges.
   always @(negedge clk) begin
      if (!rst_n) begin
         run = 0; done_n = 1'b1; prev_iso = 0;
      end else begin
         if (!$onehot0(bank_en)) st_bank_bad = 1;
         for (int i = 0; i < (1<<BANK_W); i++) if (bank_en[i]) obs_bank = i;
         if (precharge) begin
            st_pre++;
            if ((|wordline) || st_wl > 0) st_order_bad = 1;
         end
         if (|wordline) begin
            st_wl++; run++;
            if (!$onehot(wordline)) st_oh_bad = 1;
            if (st_pre == 0) st_order_bad = 1;
            if (!$onehot(bank_en)) st_bank_bad = 1;
            for (int i = 0; i < (1<<ROW_W); i++) if (wordline[i]) obs_row = i;
            for (int i = 0; i < (1<<COL_W); i++) if (col_sel[i]) obs_col = i;
            if (obs_bank >= 0 && obs_row >= 0 && obs_col >= 0) begin
               if (write_en)
                  arr[(obs_bank << (ROW_W+COL_W)) | (obs_row << COL_W) | obs_col] = wr_data;
               if (sense_en)
                  sense_data = arr[(obs_bank << (ROW_W+COL_W)) | (obs_row << COL_W) | obs_col];
            end
            done_n = !(dly_cfg != 0 && run >= dly_cfg);
         end else begin
            run = 0; done_n = 1'b1;
         end
         if (sense_iso) begin
            st_iso++;
            if (|wordline) st_iso_bad = 1;
         end
         if (rd_valid) begin
            st_rdv++;
            if (!prev_iso || !req_ready) st_rdv_bad = 1;
            st_rdata = rd_data;
         end
         prev_iso = sense_iso;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic wait_idle();
      do begin @(negedge clk); #1; end while (!req_ready);
   endtask

   // One complete access with all per-access checks.
   task automatic run_txn(input bit wr, input logic [ADDR_W-1:0] addr,
                          input logic [DATA_W-1:0] data, input int dly, input int lim);
      int lim_eff, exp_w;
      bit exp_tmo;
      lim_eff = (lim == 0) ? 1 : lim;
      exp_tmo = !(dly != 0 && dly <= lim_eff);
      exp_w   = exp_tmo ? lim_eff : dly;
      clear_stats();
      dly_cfg = dly;
      tmo_limit = TMO_W'(lim);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = data;
      @(negedge clk);
      req_valid = 1'b0;
      wait_idle();
      chk(st_pre == PRE_C && !st_order_bad, "R4", "precharge cycles", st_pre, PRE_C);
      chk(!st_oh_bad, "R3", "word line one-hot", st_oh_bad, 0);
      chk(!st_bank_bad && obs_bank == int'(addr >> (ROW_W+COL_W)), "R2", "bank enable",
          obs_bank, int'(addr >> (ROW_W+COL_W)));
      chk(obs_row == int'((addr >> COL_W) & ((1<<ROW_W)-1)) &&
          obs_col == int'(addr & ((1<<COL_W)-1)), "R1", "row/col decode",
          obs_row * 100 + obs_col,
          int'((addr >> COL_W) & ((1<<ROW_W)-1)) * 100 + int'(addr & ((1<<COL_W)-1)));
      chk(st_wl == exp_w, "R5", "word line pulse width", st_wl, exp_w);
      chk(st_iso == 1 && !st_iso_bad, "R6", "isolation cycles", st_iso, 1);
      chk(err_timeout == exp_tmo, "R9", "timeout flag", err_timeout, exp_tmo);
      if (wr) begin
         if (!exp_tmo) refm[addr] = data;
         chk(st_rdv == 0, "R7", "no read strobe on write", st_rdv, 0);
      end else if (exp_tmo) begin
         chk(st_rdv == 0, "R9", "no read strobe after timeout", st_rdv, 0);
      end else begin
         chk(st_rdv == 1 && !st_rdv_bad, "R8", "read strobe timing", st_rdv, 1);
         chk(st_rdata == refm[addr], "R8", "read data", st_rdata, refm[addr]);
      end
   endtask

   // {write, addr[8:0], data[7:0], done delay[3:0]}; read data comes from refm.
   localparam int NVEC = 12;
   localparam logic [21:0] VEC [NVEC] = '{
      {1'b1, 9'h000, 8'hA5, 4'd1},
      {1'b1, 9'h1FF, 8'h3C, 4'd3},
      {1'b1, 9'h001, 8'h11, 4'd2},
      {1'b1, 9'h004, 8'h22, 4'd2},
      {1'b1, 9'h080, 8'h33, 4'd1},
      {1'b0, 9'h000, 8'h00, 4'd2},
      {1'b0, 9'h001, 8'h00, 4'd1},
      {1'b0, 9'h004, 8'h00, 4'd4},
      {1'b0, 9'h080, 8'h00, 4'd3},
      {1'b0, 9'h1FF, 8'h00, 4'd5},
      {1'b1, 9'h155, 8'h5A, 4'd2},
      {1'b0, 9'h155, 8'h00, 4'd1}
   };

   initial begin
      for (int i = 0; i < NWORD; i++) begin arr[i] = '0; refm[i] = '0; end
      clear_stats();
      repeat (3) @(negedge clk);
      // Reset state (R10, R2, R3)
      chk(req_ready == 1'b1, "R10", "ready in reset", req_ready, 1);
      chk(wordline == '0 && bank_en == '0, "R3", "lines idle in reset", wordline, 0);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk(req_ready && !rd_valid && !err_timeout && bank_en == '0, "R2",
          "idle after reset", {req_ready, rd_valid, err_timeout, |bank_en}, 4'b1000);

      for (int v = 0; v < NVEC; v++)
         run_txn(VEC[v][21], VEC[v][20:12], VEC[v][11:4], int'(VEC[v][3:0]), 12);

      // R9: completion never arrives, limit 4.
      run_txn(1'b0, 9'h0A6, 8'h00, 0, 4);
      // R9: flag cleared by next accepted request.
      run_txn(1'b0, 9'h155, 8'h00, 2, 12);
      // R9: completion on the limit cycle wins.
      run_txn(1'b0, 9'h1FF, 8'h00, 6, 6);
      // R9: limit of zero behaves as one; write under timeout is not recorded.
      run_txn(1'b1, 9'h0C3, 8'hEE, 0, 0);
      run_txn(1'b0, 9'h001, 8'h00, 3, 1);

      // R10: request held while busy must not start another access.
      begin
         int extra_wl;
         clear_stats();
         dly_cfg = 3; tmo_limit = TMO_W'(12);
         @(negedge clk);
         req_valid = 1'b1; req_write = 1'b0; req_addr = 9'h004;
         @(negedge clk);
         req_write = 1'b1; req_addr = 9'h1FF; req_wdata = 8'hFF;
         #1;
         chk(req_ready == 1'b0, "R10", "ready low while busy", req_ready, 0);
         do begin @(negedge clk); #1; end while (!req_ready);
         req_valid = 1'b0;
         chk(st_rdv == 1 && st_rdata == refm[9'h004], "R10", "first access intact",
             st_rdata, refm[9'h004]);
         extra_wl = st_wl;
         repeat (6) @(negedge clk);
         #1;
         chk(st_wl == extra_wl && st_pre == PRE_C, "R10", "held request ignored",
             st_wl, extra_wl);
      end
      run_txn(1'b0, 9'h1FF, 8'h00, 2, 12);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL R5 watchdog expired: actual=hung expected=idle");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule